// File: doc/BRIEF.md
# Dual-Path Storing Bus Transceiver

The block moves a parameterised data word (18 bits by default) between two ports, A and B, along two independent paths: A-to-B and B-to-A. Each path has one storage element per bit. That element acts in one of three ways:

- as a see-through latch, when its transparency control is high;
- as a latch that keeps its value, when that control is low and its path strobe is idle;
- as an edge-captured register gated by an active-low strobe enable, when that control is low and the strobe rises.

Each path has its own active-low drive enable. While that enable is high, the port the path drives is released. The bidirectional pins are modelled as a data-out vector and a drive-enable bit, so the block holds no internal tri-state logic.

The block runs on one system clock. Each path strobe is sampled on that clock, and a rising edge is a sampled 1 that follows a sampled 0. A capture takes effect at the system clock edge that first sees the strobe high. Transparency is combinational: the output follows the input within the same cycle. A synchronous active-high reset clears both stored words. Reset does not touch the drive enables.

Top module: `bus_xcvr_uni`

## Requirements
- R1: While a path's drive enable input (`*_drv_n`) is 1, the port it drives has its enable output at 0 and its data output at all zeros, whatever the other inputs are.
- R2: While a path's drive enable input is 0, the enable output of the driven port is 1.
- R3: While a path's transparency input (`*_pass`) is 1 and driving is on, the driven data output equals the source input in the same cycle.
- R4: While transparency is 0 and the strobe shows no 0-to-1 change between system clock samples, the driven output keeps its stored value, including while the strobe stays high.
- R5: With transparency 0 and strobe enable (`*_stb_en_n`) 0, the first system clock edge that samples the strobe at 1 after a sample at 0 stores the source input, and the stored value appears on the output after that edge.
- R6: While strobe enable is 1, a strobe rising edge leaves the stored value unchanged.
- R7: When transparency goes from 1 to 0, the held value is the source input sampled at the last system clock edge at which transparency was 1.
- R8: Transparency takes priority over a strobe edge in the same cycle: the output follows the input, and the stored value afterwards is that input.
- R9: A synchronous reset clears both stored words to zero, and it leaves the enable outputs under the control of the drive enable inputs.
- R10: Each path uses only its own controls: activity on one path never changes the other path's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data received at port A |
| a_out | output | WIDTH | Data driven onto port A (B-to-A path) |
| a_drive | output | 1 | Port A driver enable, 1 = driving |
| b_in | input | WIDTH | Data received at port B |
| b_out | output | WIDTH | Data driven onto port B (A-to-B path) |
| b_drive | output | 1 | Port B driver enable, 1 = driving |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ab_pass | input | 1 | A-to-B transparency, active high |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |
| ba_pass | input | 1 | B-to-A transparency, active high |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The drive-enable and transparency results are combinational, so they are due in the cycle the stimulus is applied. Holding and capturing act at the next system clock edge: a strobe driven high before that edge is stored at it. The bench drives every input on the falling edge and reads the outputs at the following falling edge. By then exactly one rising edge has passed, so a single sample point covers both the combinational results and the results due after one edge. The assertions relate the output seen at one rising edge to the inputs sampled at the edge before it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_PATHS = 2;
  localparam int PATH_AB   = 0;
  localparam int PATH_BA   = 1;

  typedef struct packed {
    logic drv_n;
    logic pass;
    logic stb;
    logic stb_en_n;
  } path_ctrl_t;
endpackage

// File: rtl/xcvr_edge_sense.sv
module xcvr_edge_sense (
  input  logic clk,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  // Sampled even during reset so no false edge appears after reset.
  always_ff @(posedge clk) begin
    sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/xcvr_store_path.sv
module xcvr_store_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  path_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  logic             stb_rise;
  logic             capture;
  logic [WIDTH-1:0] held;
  logic [WIDTH-1:0] view;

  xcvr_edge_sense u_edge (
    .clk  (clk),
    .sig  (ctrl.stb),
    .rise (stb_rise)
  );

  // Transparency wins over a strobe edge.
  assign capture = ctrl.pass | (stb_rise & ~ctrl.stb_en_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (capture) begin
      held <= din;
    end
  end

  assign view  = ctrl.pass ? din : held;
  assign drive = ~ctrl.drv_n;
  assign dout  = drive ? view : '0;
endmodule

// File: rtl/bus_xcvr_uni.sv
module bus_xcvr_uni
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_drv_n,
  input  logic             ab_pass,
  input  logic             ab_stb,
  input  logic             ab_stb_en_n,
  input  logic             ba_drv_n,
  input  logic             ba_pass,
  input  logic             ba_stb,
  input  logic             ba_stb_en_n
);
  path_ctrl_t       ctrl  [NUM_PATHS];
  logic [WIDTH-1:0] src   [NUM_PATHS];
  logic [WIDTH-1:0] dst   [NUM_PATHS];
  logic             dst_en[NUM_PATHS];

  assign ctrl[PATH_AB] = '{drv_n: ab_drv_n, pass: ab_pass, stb: ab_stb, stb_en_n: ab_stb_en_n};
  assign ctrl[PATH_BA] = '{drv_n: ba_drv_n, pass: ba_pass, stb: ba_stb, stb_en_n: ba_stb_en_n};
  assign src[PATH_AB]  = a_in;
  assign src[PATH_BA]  = b_in;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    xcvr_store_path #(.WIDTH(WIDTH)) u_path (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl[p]),
      .din   (src[p]),
      .dout  (dst[p]),
      .drive (dst_en[p])
    );
  end

  assign b_out   = dst[PATH_AB];
  assign b_drive = dst_en[PATH_AB];
  assign a_out   = dst[PATH_BA];
  assign a_drive = dst_en[PATH_BA];
endmodule

// File: rtl/bus_xcvr_uni_chk.sv
module bus_xcvr_uni_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_drv_n,
  input logic             ab_pass,
  input logic             ab_stb,
  input logic             ab_stb_en_n,
  input logic             ba_drv_n,
  input logic             ba_pass,
  input logic             ba_stb,
  input logic             ba_stb_en_n
);
  a_r1_ab_released: assert property (@(posedge clk)
    ab_drv_n |-> (!b_drive && b_out == '0));

  a_r1_ba_released: assert property (@(posedge clk)
    ba_drv_n |-> (!a_drive && a_out == '0));

  a_r2_ab_driving: assert property (@(posedge clk)
    !ab_drv_n |-> b_drive);

  a_r3_ab_pass: assert property (@(posedge clk)
    (ab_pass && !ab_drv_n) |-> b_out == a_in);

  a_r3_ba_pass: assert property (@(posedge clk)
    (ba_pass && !ba_drv_n) |-> a_out == b_in);

  a_r4_ab_hold: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_drv_n && !(ab_stb && !$past(ab_stb))) ##1 (!ab_pass && !ab_drv_n)
    |-> $stable(b_out));

  a_r5_ab_capture: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_stb_en_n && ab_stb && !$past(ab_stb)) ##1 (!ab_pass && !ab_drv_n)
    |-> b_out == $past(a_in));

  a_r6_ab_blocked: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_drv_n && ab_stb_en_n) ##1 (!ab_pass && !ab_drv_n)
    |-> $stable(b_out));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst ##1 (!rst && !ab_pass && !ab_drv_n) |-> b_out == '0);
endmodule

bind bus_xcvr_uni bus_xcvr_uni_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bus_xcvr_uni_test.sv
module bus_xcvr_uni_test;
  localparam int W = 18;
  localparam int NV = 15;
  // {drv_n, pass, stb, stb_en_n, a_in, exp_drive, exp_b_out, req}
  localparam logic [44:0] TBL [NV] = '{
    {4'b0100, 18'h15555, 1'b1, 18'h15555, 4'd3},  // R3
    {4'b0100, 18'h0ABCD, 1'b1, 18'h0ABCD, 4'd3},  // R3
    {4'b0000, 18'h3FFFF, 1'b1, 18'h0ABCD, 4'd7},  // R7
    {4'b0000, 18'h12345, 1'b1, 18'h0ABCD, 4'd4},  // R4
    {4'b0010, 18'h12345, 1'b1, 18'h12345, 4'd5},  // R5
    {4'b0010, 18'h22222, 1'b1, 18'h12345, 4'd4},  // R4 strobe held high
    {4'b0000, 18'h22222, 1'b1, 18'h12345, 4'd4},  // R4
    {4'b0011, 18'h33333, 1'b1, 18'h12345, 4'd6},  // R6
    {4'b0001, 18'h33333, 1'b1, 18'h12345, 4'd6},  // R6
    {4'b0010, 18'h00001, 1'b1, 18'h00001, 4'd5},  // R5
    {4'b1010, 18'h00001, 1'b0, 18'h00000, 4'd1},  // R1
    {4'b1100, 18'h2AAAA, 1'b0, 18'h00000, 4'd1},  // R1
    {4'b0000, 18'h11111, 1'b1, 18'h2AAAA, 4'd2},  // R2, R7
    {4'b0110, 18'h3C3C3, 1'b1, 18'h3C3C3, 4'd8},  // R8
    {4'b0010, 18'h00000, 1'b1, 18'h3C3C3, 4'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;
  logic ab_drv_n = 1'b0, ab_pass = 1'b0, ab_stb = 1'b0, ab_stb_en_n = 1'b0;
  logic ba_drv_n = 1'b0, ba_pass = 1'b0, ba_stb = 1'b0, ba_stb_en_n = 1'b0;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bus_xcvr_uni #(.WIDTH(W)) uut (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R9 reset state, drive enables follow their inputs
    check("R9", b_out, '0);
    check("R9", a_out, '0);
    check("R2", {17'd0, b_drive}, 18'd1);

    for (int i = 0; i < NV; i++) begin
      {ab_drv_n, ab_pass, ab_stb, ab_stb_en_n} = TBL[i][44:41];
      a_in = TBL[i][40:23];
      b_in = ~TBL[i][40:23];
      step();
      check($sformatf("R%0d row %0d", TBL[i][3:0], i), b_out, TBL[i][21:4]);
      check($sformatf("R%0d drive row %0d", TBL[i][3:0], i), {17'd0, b_drive}, {17'd0, TBL[i][22]});
      check("R10 a_out untouched", a_out, '0);
    end

    // B-to-A path with its own controls
    ab_pass = 1'b0; ab_stb = 1'b0;
    ba_pass = 1'b1; b_in = 18'h0F0F0;
    #1 check("R3 ba pass", a_out, 18'h0F0F0);
    check("R2 ba drive", {17'd0, a_drive}, 18'd1);
    step();
    ba_pass = 1'b0; b_in = 18'h1E1E1;
    step();
    check("R7 ba hold", a_out, 18'h0F0F0);
    ba_stb = 1'b1;
    step();
    check("R5 ba capture", a_out, 18'h1E1E1);
    check("R10 b_out untouched", b_out, 18'h3C3C3);
    ba_stb = 1'b0; ba_stb_en_n = 1'b1; b_in = 18'h00FFF;
    step();
    ba_stb = 1'b1;
    step();
    check("R6 ba blocked", a_out, 18'h1E1E1);
    ba_drv_n = 1'b1;
    #1 check("R1 ba released", a_out, '0);
    check("R1 ba drive", {17'd0, a_drive}, '0);

    // R9 reset while stored words are nonzero
    ba_drv_n = 1'b0;
    rst = 1'b1;
    step();
    check("R9 drive kept in reset", {17'd0, b_drive}, 18'd1);
    rst = 1'b0;
    step();
    check("R9 ab cleared", b_out, '0);
    check("R9 ba cleared", a_out, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule